// File: doc/BRIEF.md
# Programmable Baud Clock Divider

This block divides a reference clock by a 16-bit divisor and produces a baud clock running at sixteen times the serial bit rate. That clock feeds the receive and transmit sections of a serial port. The divisor is presented as a low byte and a high byte. A one-cycle load strobe captures both bytes together. Alongside the clock output the block produces a one-cycle enable pulse. Logic running on the reference clock can use this pulse in place of the derived clock.

The output is deliberately asymmetric. For large divisors every period opens with a fixed two-cycle low phase, and the rest of the period is high. Divisors of 1, 2 and 3 each have their own waveform. A zero divisor parks the output high. A new divisor never cuts the running period short: it takes over at the next period boundary. If the output is stopped, it takes over at the next clock edge. All pins are plain control or status signals. Nothing flows through the block, so no valid/ready handshake applies.

Top module: `baud_clk_div`

## Requirements
- R1: While `rst_n` is low, and after release until the first load, `baud_out` is 1 and `tick` is 0. Asserting reset mid-period forces these values at once.
- R2: With divisor N = {`div_hi`,`div_lo`} (the high byte in bits 15:8) and N > 1, the output repeats every N reference cycles and `tick` is 1 in exactly one cycle of each period.
- R3: For N > 3, each period has 2 low cycles followed by N-2 high cycles.
- R4: For N = 3, each period has 1 low cycle followed by 2 high cycles.
- R5: For N = 2, the output alternates one cycle low and one cycle high.
- R6: For N = 1, `baud_out` equals the reference clock level and `tick` is 1 in every cycle.
- R7: N = 0 holds `baud_out` at 1 and `tick` at 0 from the next period boundary onward.
- R8: A load during a running period does not alter that period. The new divisor applies from the cycle after its last cycle.
- R9: A load while the output is stopped, or one sampled in the last cycle of a period, starts a new period on that same clock edge.
- R10: `tick` is 1 exactly in the first low cycle of each period, aligned with the falling edge of `baud_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| div_load | input | 1 | One-cycle strobe that captures both divisor bytes |
| baud_out | output | 1 | Baud clock at 16x the bit rate |
| tick | output | 1 | One-cycle pulse at the start of each baud period |

## Verification
The bench builds the block with its defaults: byte width 8, which gives a 16-bit divisor, and a low phase of 2 cycles. These values bring every waveform class within reach: the stopped output at 0, the clock-following case at 1, the short waveforms at 2 and 3, and the long waveform from 4 upward. A divisor of 259 sets a bit in the high byte, so it checks that the two bytes are joined in the right order. The reload scenarios place the strobe mid-period and also in the final cycle of a period, to separate deferred loads from immediate ones.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  // Waveform class chosen from the active divisor
  typedef enum logic [1:0] {
    MODE_STOP   = 2'd0,  // divisor zero: output parked high
    MODE_FOLLOW = 2'd1,  // divisor one: output tracks the reference clock
    MODE_SHORT  = 2'd2,  // small divisors: single low cycle
    MODE_LONG   = 2'd3   // larger divisors: fixed multi-cycle low phase
  } wave_mode_e;
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BYTE_W-1:0] byte_lo,
  input  logic [BYTE_W-1:0] byte_hi,
  input  logic             load,
  input  logic             commit,
  input  logic [DIV_W-1:0] n_cur,
  output logic [DIV_W-1:0] cand_n
);
  logic [DIV_W-1:0] pend_n;
  logic             pend_v;
  logic [DIV_W-1:0] fresh_n;

  assign fresh_n = {byte_hi, byte_lo};

  // Newest request wins; a parked request wins over the running value
  always_comb begin
    if (load)        cand_n = fresh_n;
    else if (pend_v) cand_n = pend_n;
    else             cand_n = n_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_n <= '0;
      pend_v <= 1'b0;
    end else if (commit) begin
      pend_v <= 1'b0;
    end else if (load) begin
      pend_n <= fresh_n;
      pend_v <= 1'b1;
    end
  end

  // A boundary always consumes the parked request (R8)
  assert_pend_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend_v);
  // A load that misses the boundary is held for it (R8)
  assert_pend_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !commit) |=> pend_v);
endmodule

// File: rtl/baud_div_count.sv
module baud_div_count #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cand_n,
  output logic [DIV_W-1:0] n_cur,
  output logic [DIV_W-1:0] n_nxt,
  output logic [DIV_W-1:0] cnt_nxt,
  output logic             period_end,
  output logic             start_nxt
);
  logic [DIV_W-1:0] cnt;

  assign period_end = (n_cur == '0) || (cnt == n_cur - DIV_W'(1));

  always_comb begin
    if (period_end) begin
      n_nxt   = cand_n;
      cnt_nxt = '0;
    end else begin
      n_nxt   = n_cur;
      cnt_nxt = cnt + DIV_W'(1);
    end
  end

  assign start_nxt = period_end && (cand_n != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      n_cur <= '0;
    end else begin
      cnt   <= cnt_nxt;
      n_cur <= n_nxt;
    end
  end

  // Divisor changes only at a period boundary (R8)
  assert_div_change_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_cur) |-> $past(period_end));
  // Counter stays inside the period (R2)
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (n_cur != '0) |-> (cnt < n_cur));
endmodule

// File: rtl/baud_div_shape.sv
module baud_div_shape
  import baud_div_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int LOW_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] n_cur,
  input  logic [DIV_W-1:0] n_nxt,
  input  logic [DIV_W-1:0] cnt_nxt,
  input  logic             start_nxt,
  output logic             baud_out,
  output logic             tick
);
  function automatic wave_mode_e classify(input logic [DIV_W-1:0] n);
    if (n == '0)                        return MODE_STOP;
    else if (n == DIV_W'(1))            return MODE_FOLLOW;
    else if (n <= DIV_W'(LOW_CYC + 1))  return MODE_SHORT;
    else                                return MODE_LONG;
  endfunction

  logic       level_nxt;
  logic       baud_q;
  logic       tick_q;
  wave_mode_e mode_cur;

  always_comb begin
    unique case (classify(n_nxt))
      MODE_STOP, MODE_FOLLOW: level_nxt = 1'b1;
      MODE_SHORT:             level_nxt = (cnt_nxt != '0);
      default:                level_nxt = (cnt_nxt >= DIV_W'(LOW_CYC));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= 1'b1;
      tick_q <= 1'b0;
    end else begin
      baud_q <= level_nxt;
      tick_q <= start_nxt;
    end
  end

  assign mode_cur = classify(n_cur);
  assign baud_out = (mode_cur == MODE_FOLLOW) ? clk : baud_q;
  assign tick     = tick_q;

  // Stopped divisor: parked high, no pulses (R7)
  assert_stop_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == MODE_STOP) |-> (baud_q && !tick_q));
  // Falling edge of the registered clock coincides with the pulse (R10)
  assert_fall_has_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(baud_q) |-> tick_q);
  // Pulse lasts one cycle unless the divisor is one (R2)
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && (mode_cur != MODE_FOLLOW)) |=> !tick_q);
endmodule

// File: rtl/baud_clk_div.sv
module baud_clk_div #(
  parameter int BYTE_W  = 8,
  parameter int LOW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic              div_load,
  output logic              baud_out,
  output logic              tick
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0] cand_n;
  logic [DIV_W-1:0] n_cur;
  logic [DIV_W-1:0] n_nxt;
  logic [DIV_W-1:0] cnt_nxt;
  logic             period_end;
  logic             start_nxt;

  baud_div_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .byte_lo(div_lo),
    .byte_hi(div_hi),
    .load   (div_load),
    .commit (period_end),
    .n_cur  (n_cur),
    .cand_n (cand_n)
  );

  baud_div_count #(.DIV_W(DIV_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_n    (cand_n),
    .n_cur     (n_cur),
    .n_nxt     (n_nxt),
    .cnt_nxt   (cnt_nxt),
    .period_end(period_end),
    .start_nxt (start_nxt)
  );

  baud_div_shape #(.DIV_W(DIV_W), .LOW_CYC(LOW_CYC)) u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .n_cur    (n_cur),
    .n_nxt    (n_nxt),
    .cnt_nxt  (cnt_nxt),
    .start_nxt(start_nxt),
    .baud_out (baud_out),
    .tick     (tick)
  );

  // Load while stopped starts a period on that edge (R9)
  assert_load_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_load && (n_cur == '0) && ({div_hi, div_lo} > DIV_W'(1))) |=> (tick && !baud_out));
endmodule

// File: tb/baud_clk_div_tb.sv
`timescale 1ns/1ps
module baud_clk_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_lo = '0;
  logic [7:0] div_hi = '0;
  logic       div_load = 1'b0;
  logic       baud_out;
  logic       tick;

  int n_checks = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  baud_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
    .div_load(div_load), .baud_out(baud_out), .tick(tick)
  );

  // Expected level from the waveform rules (R3, R4, R5, R7)
  function automatic logic exp_level(int c, int n);
    if (n == 0) return 1'b1;
    if (n <= 3) return (c != 0);
    return (c >= 2);
  endfunction

  task automatic chk(logic b_exp, logic t_exp, string req);
    n_checks++;
    if (baud_out !== b_exp || tick !== t_exp) begin
      n_bad++;
      $display("FAIL %s: baud_out=%b tick=%b expected baud_out=%b tick=%b at %0t",
               req, baud_out, tick, b_exp, t_exp, $time);
    end
  endtask

  // Reset, then release; ends at a negedge with the output stopped (R1)
  task automatic do_reset();
    rst_n = 1'b0;
    div_load = 1'b0;
    repeat (3) @(negedge clk);
    chk(1'b1, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b1, 1'b0, "R1 after release");
  endtask

  // Present a divisor for one edge; returns at the negedge after it
  task automatic load_div(int n);
    div_lo = n[7:0];
    div_hi = n[15:8];
    div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
  endtask

  task automatic run_div(int n, int cyc, string req);
    do_reset();
    load_div(n);
    for (int p = 0; p < cyc; p++) begin
      if (p > 0) @(negedge clk);
      chk(exp_level(p % n, n), (p % n) == 0, req);
    end
  endtask

  task automatic t_div1();
    do_reset();
    load_div(1);
    for (int p = 0; p < 6; p++) begin
      if (p > 0) @(negedge clk);
      chk(1'b0, 1'b1, "R6 low half");
      @(posedge clk); #1;
      chk(1'b1, 1'b1, "R6 high half");
    end
  endtask

  // Load mid-period: old period finishes first (R8)
  task automatic t_reload_mid();
    do_reset();
    load_div(5);
    for (int p = 0; p < 7; p++) begin
      if (p > 0) @(negedge clk);
      chk(exp_level(p % 5, 5), (p % 5) == 0, "R8 before reload");
    end
    load_div(4);
    for (int p = 7; p < 22; p++) begin
      if (p > 7) @(negedge clk);
      if (p < 10) chk(exp_level(p % 5, 5), 1'b0, "R8 old period kept");
      else        chk(exp_level((p - 10) % 4, 4), ((p - 10) % 4) == 0, "R8 new divisor");
    end
  endtask

  // Load in the last cycle of a period: immediate (R9)
  task automatic t_reload_end();
    do_reset();
    load_div(5);
    for (int p = 0; p < 5; p++) begin
      if (p > 0) @(negedge clk);
      chk(exp_level(p, 5), p == 0, "R9 before reload");
    end
    load_div(3);
    for (int p = 0; p < 9; p++) begin
      if (p > 0) @(negedge clk);
      chk(exp_level(p % 3, 3), (p % 3) == 0, "R9 R4 new divisor at once");
    end
  endtask

  task automatic t_zero();
    do_reset();
    load_div(5);
    for (int p = 0; p < 3; p++) begin
      if (p > 0) @(negedge clk);
      chk(exp_level(p, 5), p == 0, "R7 before stop");
    end
    load_div(0);
    for (int p = 3; p < 20; p++) begin
      if (p > 3) @(negedge clk);
      chk(1'b1, 1'b0, p < 5 ? "R7 R8 old period" : "R7 stopped");
    end
  endtask

  task automatic t_reset_mid();
    run_div(6, 6, "R1 pre");
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    chk(1'b1, 1'b0, "R1 async reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(1'b1, 1'b0, "R1 stays stopped");
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    run_div(5, 20, "R3 R2 R10 N=5");
    run_div(4, 16, "R3 N=4");
    run_div(16, 48, "R3 R2 N=16");
    run_div(3, 12, "R4 N=3");
    run_div(2, 10, "R5 N=2");
    run_div(259, 600, "R2 R3 high byte N=259");
    t_div1();
    t_reload_mid();
    t_reload_end();
    t_zero();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule